// File: doc/BRIEF.md
# ADC Code Transition Calibration Monitor

This block supports offset and gain trimming of a 12-bit converter with offset-binary output. A fixed test voltage is applied while the converter runs freely. The monitor watches the stream of conversion results over a window of programmable length. It counts how often each of two adjacent target codes appears. When the window closes it reports whether the input sits exactly on the boundary between the two codes, which is the case when the two counts are equal within a programmable tolerance. If the input is off the boundary, it reports which way the trim must move.

A mode input selects one of two fixed code pairs. The offset pair sits just above mid-scale. The gain pair sits at the top of the code range. Results that match neither code are counted as stray samples, split into those below the pair and those above it. Too many stray samples produce an out-of-range verdict.

The block enforces that offset is trimmed before gain. A gain measurement is refused until an offset window has closed with a balanced verdict.

The sample input is a valid/ready stream. The monitor never applies back-pressure: `s_ready` is held high, so every beat that has `s_valid` high is taken in the cycle it is offered. The source may leave gaps by dropping `s_valid`. Beats offered while no window is open are consumed and discarded. Control and status pins are plain levels or pulses.

Top module: `cal_mon`

## Requirements
- R1: After reset, `cnt_lo` and `cnt_hi` are 0, `status` is 5 (no verdict), and `done`, `busy` and `order_err` are 0.
- R2: A `start` pulse accepted while idle clears all counts, raises `busy` and lowers `done` on the next cycle. The window closes after `win_len` accepted samples, where a `win_len` of 0 acts as 1. In the cycle after the last sample, `busy` falls and `done` rises.
- R3: During a window, `cnt_lo` counts samples equal to the lower code of the pair and `cnt_hi` counts samples equal to the upper code. After `done` rises, the counts and `status` hold until the next accepted start.
- R4: With `mode`=0 (offset) the pair is 0x800/0x801. With `mode`=1 (gain) the pair is 0xFFE/0xFFF. The mode is captured at the accepted start and changes to `mode` during the window have no effect.
- R5: When the stray count is within its limit, the verdict is decided as follows. If |cnt_lo − cnt_hi| ≤ `tol`, status is 0 (balanced). Otherwise status is 1 (too low) when cnt_lo is larger and 2 (too high) when cnt_hi is larger.
- R6: A sample matching neither code is stray. It counts as below the pair if it is less than the lower code and as above the pair otherwise. If the total stray count exceeds `stray_lim`, status is 3 (out of range, below) when the below count is larger than the above count, and 4 (out of range, above) otherwise.
- R7: A `start` pulse received while `busy` is high is ignored: the window and its counts continue unchanged.
- R8: A gain start is refused while no offset window has closed balanced. A refused start opens no window, sets `order_err`, clears the counts and sets status to 5. The permission is set when an offset window closes with status 0 and cleared when one closes with any other status. An accepted start clears `order_err`.
- R9: `s_ready` is always 1. A beat with `s_valid` high is counted only while `busy` is high. Beats offered while idle leave the counts unchanged.
- R10: While `done` is 0, `status` reads 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that opens a measurement window |
| mode | input | 1 | 0 selects the offset pair, 1 selects the gain pair |
| win_len | input | 16 | Window length in accepted samples |
| tol | input | 16 | Allowed absolute count difference for a balanced verdict |
| stray_lim | input | 16 | Largest stray count still treated as in range |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Sample beat ready, always high |
| s_data | input | 12 | Conversion result, offset binary |
| cnt_lo | output | 16 | Count of the lower target code |
| cnt_hi | output | 16 | Count of the upper target code |
| status | output | 3 | Verdict: 0 balanced, 1 too low, 2 too high, 3 out of range below, 4 out of range above, 5 none |
| done | output | 1 | Window closed; results frozen |
| busy | output | 1 | Window open |
| order_err | output | 1 | Last start was a refused gain start |

## Verification
Some properties are checked on every cycle by assertions:
- `done` and `busy` are never high together, and `done` rises only as `busy` falls.
- The lower-code count advances by at most one per cycle inside a window.
- Frozen results stay still.
- A verdict is visible only while `done` is high.
- A refused start never opens a window.

Other behaviour can only be shown by the bench's scenarios, which run a behavioural model alongside the design:
- the actual verdict values for balanced, skewed and stray-heavy sample mixes;
- the offset-before-gain permission as it is granted and revoked;
- capture of the mode at start;
- the zero-length window;
- discarding of beats while idle.

// File: rtl/cal_mon_pkg.sv
package cal_mon_pkg;
  typedef enum logic [2:0] {
    ST_BAL       = 3'd0,
    ST_LOW       = 3'd1,
    ST_HIGH      = 3'd2,
    ST_OOR_BELOW = 3'd3,
    ST_OOR_ABOVE = 3'd4,
    ST_NONE      = 3'd5
  } cal_status_e;

  typedef enum logic [1:0] {
    CL_LO    = 2'd0,
    CL_HI    = 2'd1,
    CL_BELOW = 2'd2,
    CL_ABOVE = 2'd3
  } cal_class_e;

  localparam int NCLASS = 4;
endpackage

// File: rtl/cal_classify.sv
module cal_classify
  import cal_mon_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          gain_mode,
  input  logic [DW-1:0] code,
  output cal_class_e    cls
);
  // Offset pair: MSB set, rest clear, and its successor.
  localparam logic [DW-1:0] OFS_LO  = {1'b1, {(DW-1){1'b0}}};
  // Gain pair: all ones but the LSB, and all ones.
  localparam logic [DW-1:0] GAIN_LO = {{(DW-1){1'b1}}, 1'b0};
  localparam logic [DW-1:0] ONE     = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] pair_lo, pair_hi;

  assign pair_lo = gain_mode ? GAIN_LO : OFS_LO;
  assign pair_hi = pair_lo + ONE;

  always_comb begin
    if (code == pair_lo)      cls = CL_LO;
    else if (code == pair_hi) cls = CL_HI;
    else if (code < pair_lo)  cls = CL_BELOW;
    else                      cls = CL_ABOVE;
  end
endmodule

// File: rtl/cal_verdict.sv
module cal_verdict
  import cal_mon_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0] n_lo,
  input  logic [CW-1:0] n_hi,
  input  logic [CW-1:0] n_below,
  input  logic [CW-1:0] n_above,
  input  logic [CW-1:0] tol,
  input  logic [CW-1:0] lim,
  output cal_status_e   verdict
);
  logic [CW:0]   stray;
  logic [CW-1:0] diff;

  assign stray = {1'b0, n_below} + {1'b0, n_above};
  assign diff  = (n_lo >= n_hi) ? (n_lo - n_hi) : (n_hi - n_lo);

  always_comb begin
    if (stray > {1'b0, lim})
      verdict = (n_below > n_above) ? ST_OOR_BELOW : ST_OOR_ABOVE;
    else if (diff <= tol)
      verdict = ST_BAL;
    else if (n_lo > n_hi)
      verdict = ST_LOW;
    else
      verdict = ST_HIGH;
  end
endmodule

// File: rtl/cal_mon.sv
module cal_mon
  import cal_mon_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [CW-1:0] win_len,
  input  logic [CW-1:0] tol,
  input  logic [CW-1:0] stray_lim,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic [CW-1:0] cnt_lo,
  output logic [CW-1:0] cnt_hi,
  output logic [2:0]    status,
  output logic          done,
  output logic          busy,
  output logic          order_err
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic        busy_q, done_q, err_q, ofs_ok_q, mode_q;
  cal_status_e status_q;
  logic [CW-1:0] n_q, target_q;
  logic [NCLASS-1:0][CW-1:0] cnt_q;
  logic [NCLASS-1:0][CW-1:0] cnt_nxt;
  cal_class_e  cls;
  cal_status_e verdict;
  logic        accept, launch, refuse, last;

  // The monitor never stalls the converter stream.
  assign s_ready = 1'b1;
  assign accept  = busy_q & s_valid;
  assign launch  = start & ~busy_q & ~(mode & ~ofs_ok_q);
  assign refuse  = start & ~busy_q & mode & ~ofs_ok_q;
  assign last    = accept & ((n_q + ONE) == target_q);

  cal_classify #(.DW(DW)) u_classify (
    .gain_mode (mode_q),
    .code      (s_data),
    .cls       (cls)
  );

  // One occurrence counter per sample class.
  for (genvar g = 0; g < NCLASS; g++) begin : g_cnt
    logic [CW-1:0] r;
    logic          hit;
    assign hit        = accept & (2'(cls) == 2'(g));
    assign cnt_nxt[g] = r + (hit ? ONE : '0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                r <= '0;
      else if (launch || refuse) r <= '0;
      else if (hit)              r <= cnt_nxt[g];
    end
    assign cnt_q[g] = r;
  end

  cal_verdict #(.CW(CW)) u_verdict (
    .n_lo    (cnt_nxt[CL_LO]),
    .n_hi    (cnt_nxt[CL_HI]),
    .n_below (cnt_nxt[CL_BELOW]),
    .n_above (cnt_nxt[CL_ABOVE]),
    .tol     (tol),
    .lim     (stray_lim),
    .verdict (verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      ofs_ok_q <= 1'b0;
      mode_q   <= 1'b0;
      status_q <= ST_NONE;
      n_q      <= '0;
      target_q <= ONE;
    end else if (refuse) begin
      err_q    <= 1'b1;
      done_q   <= 1'b0;
      status_q <= ST_NONE;
    end else if (launch) begin
      err_q    <= 1'b0;
      busy_q   <= 1'b1;
      done_q   <= 1'b0;
      status_q <= ST_NONE;
      mode_q   <= mode;
      n_q      <= '0;
      target_q <= (win_len == '0) ? ONE : win_len;
    end else if (accept) begin
      n_q <= n_q + ONE;
      if (last) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        status_q <= verdict;
        if (!mode_q) ofs_ok_q <= (verdict == ST_BAL);
      end
    end
  end

  assign cnt_lo    = cnt_q[CL_LO];
  assign cnt_hi    = cnt_q[CL_HI];
  assign status    = status_q;
  assign done      = done_q;
  assign busy      = busy_q;
  assign order_err = err_q;
endmodule

// File: rtl/cal_mon_chk.sv
module cal_mon_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          order_err,
  input logic [2:0]    status,
  input logic [CW-1:0] cnt_lo,
  input logic [CW-1:0] cnt_hi
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  a_r2_done_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  a_r2_done_rises_as_busy_falls: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  a_r3_lo_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_lo == $past(cnt_lo)) || (cnt_lo == $past(cnt_lo) + ONE));

  a_r3_results_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(cnt_lo) && $stable(cnt_hi) && $stable(status));

  a_r7_start_in_window_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  a_r8_refusal_opens_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    order_err |-> !busy);

  a_r10_no_verdict_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (status == 3'd5));
endmodule

bind cal_mon cal_mon_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .order_err (order_err),
  .status    (status),
  .cnt_lo    (cnt_lo),
  .cnt_hi    (cnt_hi)
);

// File: tb/cal_mon_bench.sv
module cal_mon_bench;
  logic        clk = 1'b0;
  logic        rst_n, start, mode, s_valid;
  logic [15:0] win_len, tol, stray_lim;
  logic [11:0] s_data;
  logic        s_ready, done, busy, order_err;
  logic [15:0] cnt_lo, cnt_hi;
  logic [2:0]  status;

  int vectors = 0;
  int fails   = 0;

  // behavioural reference state
  int m_lo = 0, m_hi = 0, m_bel = 0, m_abv = 0, m_n = 0, m_tgt = 1;
  int m_busy = 0, m_done = 0, m_err = 0, m_ok = 0, m_mode = 0, m_status = 5;
  int m_code;

  cal_mon u_cal_mon (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .win_len(win_len),
    .tol(tol), .stray_lim(stray_lim), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .status(status),
    .done(done), .busy(busy), .order_err(order_err)
  );

  always #10 clk = ~clk;

  function automatic int judge();
    int d;
    if (m_bel + m_abv > int'(stray_lim)) return (m_bel > m_abv) ? 3 : 4;
    d = (m_lo > m_hi) ? m_lo - m_hi : m_hi - m_lo;
    if (d <= int'(tol)) return 0;
    return (m_lo > m_hi) ? 1 : 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_bel = 0; m_abv = 0; m_n = 0; m_tgt = 1;
      m_busy = 0; m_done = 0; m_err = 0; m_ok = 0; m_mode = 0; m_status = 5;
    end else if (start && m_busy == 0) begin
      m_lo = 0; m_hi = 0; m_bel = 0; m_abv = 0; m_done = 0; m_status = 5;
      if (mode && m_ok == 0) m_err = 1;
      else begin
        m_err = 0; m_busy = 1; m_mode = int'(mode); m_n = 0;
        m_tgt = (win_len == 16'd0) ? 1 : int'(win_len);
      end
    end else if (m_busy == 1 && s_valid) begin
      m_code = (m_mode == 1) ? 'hFFE : 'h800;
      if (int'(s_data) == m_code)          m_lo++;
      else if (int'(s_data) == m_code + 1) m_hi++;
      else if (int'(s_data) < m_code)      m_bel++;
      else                                 m_abv++;
      m_n++;
      if (m_n == m_tgt) begin
        m_busy = 0; m_done = 1; m_status = judge();
        if (m_mode == 0) m_ok = (m_status == 0) ? 1 : 0;
      end
    end
  end

  task automatic cmp(input int act, input int exp, input string tag);
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // model comparison on every cycle
  always @(negedge clk) begin
    vectors++;
    cmp(int'(cnt_lo), m_lo, "R3 cnt_lo");
    cmp(int'(cnt_hi), m_hi, "R3 cnt_hi");
    cmp(int'(status), m_status, "R5/R6 status");
    cmp(int'(done), m_done, "R2 done");
    cmp(int'(busy), m_busy, "R2 busy");
    cmp(int'(order_err), m_err, "R8 order_err");
    cmp(int'(s_ready), 1, "R9 s_ready");
  end

  task automatic expect_eq(input int act, input int exp, input string tag);
    vectors++;
    cmp(act, exp, tag);
  endtask

  function automatic logic [11:0] gen(input int m, input int kind, input int i);
    logic [11:0] lo, hi;
    lo = (m == 1) ? 12'hFFE : 12'h800;
    hi = lo + 12'd1;
    case (kind)
      0: return (i % 2 == 0) ? lo : hi;
      1: return (i % 4 == 3) ? hi : lo;
      2: return (i % 4 == 3) ? lo : hi;
      3: return (i % 2 == 0) ? lo - 12'd5 : (((i / 2) % 2 == 1) ? hi : lo);
      default: return (i % 2 == 0) ? 12'h900 : (((i / 2) % 2 == 1) ? hi : lo);
    endcase
  endfunction

  task automatic pulse_start(input logic m);
    mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input int m, input int len, input int kind, input bit mid);
    int n, i;
    logic v;
    n = (len == 0) ? 1 : len;
    i = 0;
    win_len = 16'(len);
    pulse_start(m[0]);
    mode = ~m[0];  // R4: mode changes mid-window have no effect
    while (i < n) begin
      v = ($urandom % 4) != 0;
      s_valid = v;
      s_data  = v ? gen(m, kind, i) : 12'h123;
      start   = mid && (i == n / 2);
      if (v) i++;
      @(negedge clk);
    end
    start = 1'b0;
    s_valid = 1'b0;
  endtask

  task automatic idle_junk();
    s_valid = 1'b1;
    s_data  = 12'h800;
    repeat (3) @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: got no finish expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 1'b0; s_valid = 1'b0; s_data = '0;
    win_len = 16'd20; tol = 16'd1; stray_lim = 16'd2;
    repeat (3) @(negedge clk);
    expect_eq(int'(status), 5, "R1 status");
    expect_eq(int'(done), 0, "R1 done");
    expect_eq(int'(cnt_lo), 0, "R1 cnt_lo");
    rst_n = 1'b1;
    @(negedge clk);

    // R8: gain before any offset balance is refused
    pulse_start(1'b1);
    expect_eq(int'(order_err), 1, "R8 refused gain");
    expect_eq(int'(busy), 0, "R8 no window");

    // R5 balanced offset, with an ignored start mid-window (R7)
    run(0, 20, 0, 1'b1);
    expect_eq(int'(status), 0, "R5 balanced");
    expect_eq(int'(cnt_lo), 10, "R7 cnt_lo unaffected");
    expect_eq(int'(cnt_hi), 10, "R7 cnt_hi unaffected");
    idle_junk();
    expect_eq(int'(cnt_lo), 10, "R9 idle beats dropped");
    expect_eq(int'(done), 1, "R3 still done");

    // R5 too low; revokes gain permission
    run(0, 16, 1, 1'b0);
    expect_eq(int'(status), 1, "R5 too low");
    expect_eq(int'(cnt_lo), 12, "R3 lo count");
    pulse_start(1'b1);
    expect_eq(int'(order_err), 1, "R8 permission revoked");

    // re-balance offset, then gain measurement (R4)
    run(0, 12, 0, 1'b0);
    expect_eq(int'(status), 0, "R5 balanced again");
    run(1, 12, 2, 1'b0);
    expect_eq(int'(order_err), 0, "R8 gain accepted");
    expect_eq(int'(status), 2, "R4 gain too high");
    expect_eq(int'(cnt_hi), 9, "R4 gain hi count");
    expect_eq(int'(cnt_lo), 3, "R4 gain lo count");

    // R6 stray samples
    run(0, 10, 3, 1'b0);
    expect_eq(int'(status), 3, "R6 out of range below");
    run(0, 10, 4, 1'b0);
    expect_eq(int'(status), 4, "R6 out of range above");
    expect_eq(int'(cnt_lo), 3, "R6 lo count");

    // R2 zero-length window acts as one
    run(0, 0, 0, 1'b0);
    expect_eq(int'(done), 1, "R2 zero window done");
    expect_eq(int'(cnt_lo), 1, "R2 zero window count");
    expect_eq(int'(status), 0, "R5 diff within tol");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule